// File: doc/BRIEF.md
# Debug Mode Exception Controller

This block records whether a processor core has been halted into debug mode and decides what happens to exceptions while it is halted. An entry request saves the current program counter and status word into two save/restore registers, raises the debug/freeze flag and clears the external-interrupt enable bit. Once halted, exceptions are never taken. Each one sets its bit in an eight-bit cause register and drives a report strobe to the debug host. Execution then carries on in debug mode, and the save/restore registers stay as they are.

In debug mode every instruction fetch is steered to the development port. Load and store traffic always goes to real memory. Breakpoint and watchpoint events are dropped in debug mode. External and decrementer events are recognised only when the enable bit is set. If debug software sets that bit again, a held external interrupt level is reported on every clock. Retiring a return-from-interrupt instruction ends debug mode.

Top module: `dbg_exc_ctrl`

## Requirements
- R1: `fetch_sel_dev` is high in exactly those cycles where `fetch_req` is high and `debug_mode` is high, regardless of address.
- R2: `ls_sel_mem` equals `ls_req` in every cycle, in and out of debug mode.
- R3: After reset `debug_mode`, `srr0`, `srr1`, `ee_bit` and `cause_reg` are zero. An `enter_req` seen at a clock edge while not in debug mode sets `debug_mode` and loads `srr0` with `cur_pc` and `srr1` with `cur_msr`.
- R4: While `debug_mode` is high, `srr0` and `srr1` do not change, whatever `enter_req`, exceptions or the RI bit do.
- R5: The edge that enters debug mode clears `ee_bit`, and this takes priority over a write in the same cycle. Otherwise an `ee_wr` strobe loads `ee_bit` with `ee_val`.
- R6: Cause bit positions are 0 external, 1 decrementer, 2 alignment, 3 program, 4 system call, 5 illegal opcode, 6 breakpoint, 7 watchpoint. A recognised exception in debug mode is OR-ed into `cause_reg` at the next edge, and bits already set are kept.
- R7: `exc_report` is high in the same cycle as a recognised exception, before the next fetch, and only in those cycles. A single-cycle event gives a single-cycle pulse.
- R8: Bits 6 and 7 of `exc_evt` never set a cause bit or `exc_report`, whatever value `cur_msr` holds.
- R9: Bits 0 and 1 are recognised only while `ee_bit` is 1. A held external level with `ee_bit` set gives `exc_report` on every clock.
- R10: `host_rd` clears `cause_reg` at the next edge. A cause recognised in the same cycle as `host_rd` is still present afterwards.
- R11: `rfi_retire` in debug mode clears `debug_mode` at the next edge. Outside debug mode it has no effect.
- R12: Outside debug mode, exceptions change neither `cause_reg` nor `exc_report`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Request to halt into debug mode |
| cur_pc | input | ADDR_W | Program counter to save on entry |
| cur_msr | input | MSR_W | Status word to save on entry |
| exc_evt | input | NCAUSE | One exception event line per cause |
| ee_wr | input | 1 | Write strobe for the interrupt enable bit |
| ee_val | input | 1 | Value written to the enable bit |
| fetch_req | input | 1 | Instruction fetch request this cycle |
| ls_req | input | 1 | Load/store request this cycle |
| rfi_retire | input | 1 | Return-from-interrupt retired this cycle |
| host_rd | input | 1 | Debug host reads the cause register |
| debug_mode | output | 1 | Debug/freeze flag |
| srr0 | output | ADDR_W | Saved program counter |
| srr1 | output | MSR_W | Saved status word |
| exc_report | output | 1 | Exception report strobe to the host |
| cause_reg | output | NCAUSE | Cause register |
| ee_bit | output | 1 | External/decrementer interrupt enable |
| fetch_sel_dev | output | 1 | Fetch is routed to the development port |
| ls_sel_mem | output | 1 | Load/store is routed to real memory |

## Verification
Two cases can meet in one cycle. In the first, a host read of the cause register coincides with a newly recognised exception. The clear and the OR must then combine so that the new bit survives and the old bits are gone. In the second, an entry request and an enable-bit write arrive together, and entry must win. Directed sequences force both collisions. The random phase also produces them at a useful rate, because reads and enable writes are drawn often. After each edge a bench model predicts the register contents and compares them at the ports.

// File: rtl/dbg_exc_pkg.sv
package dbg_exc_pkg;
   localparam int unsigned CAUSE_N   = 8;
   localparam int unsigned C_EXT     = 0;
   localparam int unsigned C_DEC     = 1;
   localparam int unsigned C_ALIGN   = 2;
   localparam int unsigned C_PROG    = 3;
   localparam int unsigned C_SYSCALL = 4;
   localparam int unsigned C_ILLOP   = 5;
   localparam int unsigned C_BKPT    = 6;
   localparam int unsigned C_WATCH   = 7;

   typedef enum logic [1:0] {
      CLS_ALWAYS = 2'd0,
      CLS_GATED  = 2'd1,
      CLS_MUTED  = 2'd2
   } cause_cls_e;

   function automatic cause_cls_e cause_class(input int unsigned idx);
      if (idx == C_EXT || idx == C_DEC)         return CLS_GATED;
      else if (idx == C_BKPT || idx == C_WATCH) return CLS_MUTED;
      else                                      return CLS_ALWAYS;
   endfunction
endpackage

// File: rtl/dbg_mode_ctl.sv
module dbg_mode_ctl #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned MSR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enter_req,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [MSR_W-1:0]  cur_msr,
   input  logic              rfi_retire,
   input  logic              ee_wr,
   input  logic              ee_val,
   output logic              debug_q,
   output logic [ADDR_W-1:0] srr0_q,
   output logic [MSR_W-1:0]  srr1_q,
   output logic              ee_q
);
   logic do_enter;
   logic do_exit;

   assign do_enter = enter_req & ~debug_q;
   assign do_exit  = rfi_retire & debug_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         debug_q <= 1'b0;
         srr0_q  <= '0;
         srr1_q  <= '0;
      end else if (do_enter) begin
         debug_q <= 1'b1;
         srr0_q  <= cur_pc;
         srr1_q  <= cur_msr;
      end else if (do_exit) begin
         debug_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        ee_q <= 1'b0;
      else if (do_enter) ee_q <= 1'b0;
      else if (ee_wr)    ee_q <= ee_val;
   end
endmodule

// File: rtl/dbg_cause_log.sv
module dbg_cause_log
   import dbg_exc_pkg::*;
#(
   parameter int unsigned NCAUSE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              debug_q,
   input  logic              ee_q,
   input  logic [NCAUSE-1:0] exc_evt,
   input  logic              host_rd,
   output logic [NCAUSE-1:0] cause_q,
   output logic              report
);
   logic [NCAUSE-1:0] accepted;
   logic [NCAUSE-1:0] logged;

   for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
      if (cause_class(i) == CLS_GATED) begin : g_gated
         assign accepted[i] = exc_evt[i] & ee_q;
      end else if (cause_class(i) == CLS_MUTED) begin : g_muted
         assign accepted[i] = exc_evt[i] & 1'b0;
      end else begin : g_plain
         assign accepted[i] = exc_evt[i];
      end
   end

   assign logged = debug_q ? accepted : '0;
   assign report = |logged;

   always_ff @(posedge clk) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= (host_rd ? '0 : cause_q) | logged;
   end
endmodule

// File: rtl/dbg_route.sv
module dbg_route (
   input  logic debug_q,
   input  logic fetch_req,
   input  logic ls_req,
   output logic fetch_sel_dev,
   output logic ls_sel_mem
);
   assign fetch_sel_dev = fetch_req & debug_q;
   assign ls_sel_mem    = ls_req;
endmodule

// File: rtl/dbg_exc_ctrl.sv
module dbg_exc_ctrl #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned MSR_W  = 32,
   parameter int unsigned NCAUSE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enter_req,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [MSR_W-1:0]  cur_msr,
   input  logic [NCAUSE-1:0] exc_evt,
   input  logic              ee_wr,
   input  logic              ee_val,
   input  logic              fetch_req,
   input  logic              ls_req,
   input  logic              rfi_retire,
   input  logic              host_rd,
   output logic              debug_mode,
   output logic [ADDR_W-1:0] srr0,
   output logic [MSR_W-1:0]  srr1,
   output logic              exc_report,
   output logic [NCAUSE-1:0] cause_reg,
   output logic              ee_bit,
   output logic              fetch_sel_dev,
   output logic              ls_sel_mem
);
   if (NCAUSE != dbg_exc_pkg::CAUSE_N) begin : g_bad_ncause
      $error("NCAUSE must equal the fixed cause map width");
   end
   if (ADDR_W < 2 || MSR_W < 2) begin : g_bad_width
      $error("ADDR_W and MSR_W must be at least 2");
   end

   dbg_mode_ctl #(.ADDR_W(ADDR_W), .MSR_W(MSR_W)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .enter_req (enter_req),
      .cur_pc    (cur_pc),
      .cur_msr   (cur_msr),
      .rfi_retire(rfi_retire),
      .ee_wr     (ee_wr),
      .ee_val    (ee_val),
      .debug_q   (debug_mode),
      .srr0_q    (srr0),
      .srr1_q    (srr1),
      .ee_q      (ee_bit)
   );

   dbg_cause_log #(.NCAUSE(NCAUSE)) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .debug_q (debug_mode),
      .ee_q    (ee_bit),
      .exc_evt (exc_evt),
      .host_rd (host_rd),
      .cause_q (cause_reg),
      .report  (exc_report)
   );

   dbg_route u_route (
      .debug_q      (debug_mode),
      .fetch_req    (fetch_req),
      .ls_req       (ls_req),
      .fetch_sel_dev(fetch_sel_dev),
      .ls_sel_mem   (ls_sel_mem)
   );
endmodule

// File: rtl/dbg_exc_ctrl_chk.sv
module dbg_exc_ctrl_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned MSR_W  = 32,
   parameter int unsigned NCAUSE = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enter_req,
   input logic [NCAUSE-1:0] exc_evt,
   input logic              fetch_req,
   input logic              ls_req,
   input logic              rfi_retire,
   input logic              host_rd,
   input logic              debug_mode,
   input logic [ADDR_W-1:0] srr0,
   input logic [MSR_W-1:0]  srr1,
   input logic              exc_report,
   input logic [NCAUSE-1:0] cause_reg,
   input logic              ee_bit,
   input logic              fetch_sel_dev,
   input logic              ls_sel_mem
);
   import dbg_exc_pkg::*;

   AST_FETCH_TO_DEV: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && debug_mode) |-> fetch_sel_dev);                       // R1
   AST_LS_TO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      ls_req |-> ls_sel_mem);                                             // R2
   AST_ENTRY_SETS_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_req && !debug_mode) |=> debug_mode);                         // R3
   AST_SRR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(debug_mode) |-> ($stable(srr0) && $stable(srr1)));            // R4
   AST_ENTRY_CLEARS_EE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(debug_mode) |-> !ee_bit);                                     // R5
   AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_reg[C_ALIGN] && !host_rd) |=> cause_reg[C_ALIGN]);           // R6
   AST_BKPT_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
      ((exc_evt & ~(NCAUSE'(1) << C_BKPT) & ~(NCAUSE'(1) << C_WATCH)) == '0)
      |-> !exc_report);                                                   // R8
   AST_KEEP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && debug_mode && exc_evt[C_PROG]) |=> cause_reg[C_PROG]);  // R10
   AST_RFI_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (debug_mode && rfi_retire) |=> !debug_mode);                        // R11
   AST_NO_REPORT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !debug_mode |-> !exc_report);                                       // R12
endmodule

bind dbg_exc_ctrl dbg_exc_ctrl_chk #(
   .ADDR_W(ADDR_W), .MSR_W(MSR_W), .NCAUSE(NCAUSE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exc_evt(exc_evt),
   .fetch_req(fetch_req), .ls_req(ls_req), .rfi_retire(rfi_retire),
   .host_rd(host_rd), .debug_mode(debug_mode), .srr0(srr0), .srr1(srr1),
   .exc_report(exc_report), .cause_reg(cause_reg), .ee_bit(ee_bit),
   .fetch_sel_dev(fetch_sel_dev), .ls_sel_mem(ls_sel_mem)
);

// File: tb/dbg_exc_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_exc_ctrl_bench;
   localparam int AW = 32;
   localparam int MW = 32;
   localparam int NC = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enter_req = 1'b0;
   logic [AW-1:0] cur_pc = '0;
   logic [MW-1:0] cur_msr = '0;
   logic [NC-1:0] exc_evt = '0;
   logic          ee_wr = 1'b0, ee_val = 1'b0;
   logic          fetch_req = 1'b0, ls_req = 1'b0;
   logic          rfi_retire = 1'b0, host_rd = 1'b0;
   logic          debug_mode, exc_report, ee_bit, fetch_sel_dev, ls_sel_mem;
   logic [AW-1:0] srr0;
   logic [MW-1:0] srr1;
   logic [NC-1:0] cause_reg;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic          m_dbg = 0, m_ee = 0;
   logic [AW-1:0] m_srr0 = '0;
   logic [MW-1:0] m_srr1 = '0;
   logic [NC-1:0] m_cause = '0;

   always #2.5 clk = ~clk;

   dbg_exc_ctrl #(.ADDR_W(AW), .MSR_W(MW), .NCAUSE(NC)) u_dbg_exc_ctrl (
      .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .cur_pc(cur_pc),
      .cur_msr(cur_msr), .exc_evt(exc_evt), .ee_wr(ee_wr), .ee_val(ee_val),
      .fetch_req(fetch_req), .ls_req(ls_req), .rfi_retire(rfi_retire),
      .host_rd(host_rd), .debug_mode(debug_mode), .srr0(srr0), .srr1(srr1),
      .exc_report(exc_report), .cause_reg(cause_reg), .ee_bit(ee_bit),
      .fetch_sel_dev(fetch_sel_dev), .ls_sel_mem(ls_sel_mem)
   );

   // Accepted causes: bits 0,1 need EE; bits 6,7 never; 2..5 always.
   function automatic logic [NC-1:0] accept(input logic [NC-1:0] ev, input logic ee, input logic dbg);
      logic [NC-1:0] m;
      m = {2'b00, 4'b1111, ee, ee};
      return dbg ? (ev & m) : '0;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Called #1 after negedge with inputs settled: compare, then advance model.
   task automatic check_and_advance();
      logic [NC-1:0] acc;
      acc = accept(exc_evt, m_ee, m_dbg);
      chk("R1 fetch route", 64'(fetch_sel_dev), 64'(fetch_req & m_dbg));
      chk("R2 ls route", 64'(ls_sel_mem), 64'(ls_req));
      chk("R3 debug flag", 64'(debug_mode), 64'(m_dbg));
      chk("R4 srr0", 64'(srr0), 64'(m_srr0));
      chk("R4 srr1", 64'(srr1), 64'(m_srr1));
      chk("R5 ee", 64'(ee_bit), 64'(m_ee));
      chk("R6 cause", 64'(cause_reg), 64'(m_cause));
      chk("R7 report", 64'(exc_report), 64'(|acc));
      m_cause = (host_rd ? '0 : m_cause) | acc;
      if (!m_dbg && enter_req) begin
         m_dbg = 1; m_srr0 = cur_pc; m_srr1 = cur_msr; m_ee = 0;
      end else begin
         if (m_dbg && rfi_retire) m_dbg = 0;
         if (ee_wr) m_ee = ee_val;
      end
   endtask

   task automatic cyc();
      #1;
      check_and_advance();
      @(negedge clk);
   endtask

   task automatic idle();
      enter_req = 0; exc_evt = '0; ee_wr = 0; ee_val = 0;
      fetch_req = 0; ls_req = 0; rfi_retire = 0; host_rd = 0;
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R3 reset state
      cyc();
      // R12: exceptions outside debug ignored; R1 no routing outside
      exc_evt = 8'h3C; fetch_req = 1; ls_req = 1; rfi_retire = 1; cyc(); idle();
      cyc();
      // R5: EE set, then entry with simultaneous ee write -> entry wins
      ee_wr = 1; ee_val = 1; cyc(); idle();
      enter_req = 1; cur_pc = 32'h0000_1F00; cur_msr = 32'h0000_8002;
      ee_wr = 1; ee_val = 1; cyc(); idle();
      // R1/R2 routing in debug
      fetch_req = 1; ls_req = 1; cyc(); idle();
      // R4: second enter ignored
      enter_req = 1; cur_pc = 32'hDEAD_BEEF; cur_msr = 32'hFFFF_FFFF; cyc(); idle();
      // R8: breakpoint and watchpoint with RI set
      cur_msr = 32'h0000_0002; exc_evt = 8'hC0; cyc(); idle(); cyc();
      // R9: ext masked with EE=0
      exc_evt = 8'h03; cyc(); idle(); cyc();
      // R9: EE forced high, level ext reports every clock
      ee_wr = 1; ee_val = 1; cyc(); idle();
      exc_evt = 8'h01; fetch_req = 1; repeat (4) cyc(); idle();
      ee_wr = 1; ee_val = 0; cyc(); idle();
      // R7: one-cycle alignment event gives one-cycle pulse
      exc_evt = 8'h04; cyc(); idle(); cyc(); cyc();
      // R10: read while a new cause arrives
      host_rd = 1; exc_evt = 8'h08; cyc(); idle(); cyc();
      host_rd = 1; cyc(); idle(); cyc();
      // R11: rfi exits
      rfi_retire = 1; cyc(); idle(); fetch_req = 1; exc_evt = 8'h10; cyc(); idle(); cyc();
      // random phase
      for (int n = 0; n < 3000; n++) begin
         enter_req  = ($urandom_range(0, 15) == 0);
         rfi_retire = ($urandom_range(0, 15) == 0);
         cur_pc     = $urandom();
         cur_msr    = $urandom();
         exc_evt    = ($urandom_range(0, 2) == 0) ? 8'($urandom()) : '0;
         ee_wr      = ($urandom_range(0, 5) == 0);
         ee_val     = 1'($urandom());
         fetch_req  = 1'($urandom());
         ls_req     = 1'($urandom());
         host_rd    = ($urandom_range(0, 3) == 0);
         cyc();
      end
      idle(); cyc();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule